// File: doc/BRIEF.md
# Vector Dependence Scoreboard with Early Read Release

This block sits beside the issue stage of a multi-lane vector unit. Each instruction that enters is given a table slot, whose index serves as the instruction's ID. The slot records which vector registers the instruction reads and which one it writes. The slot's dependences are worked out against every older instruction still in flight. From then on the block reports, per slot, whether that instruction may be issued.

Three kinds of hazard are tracked, and each has its own release point:

- **Read-after-write.** The dependence lasts only until the producer has been issued. A consumer can therefore chain behind a producer that is still running, with no barrier at instruction completion.
- **Write-after-read.** The dependence lasts until every lane has reported that it finished reading the older instruction's sources. This can happen long before that instruction completes.
- **Write-after-write.** The dependence lasts until the older writer has completed.

A slot is returned to the free pool once all lanes have reported completion. Events that arrive in the same cycle as a dispatch are taken into account when the new instruction's dependences are computed.

Top module: `vec_dep_scoreboard`

## Requirements
- R1: While and after reset, `dispReady` is 1, `dispId` is 0 and `issueAllowed` is all zeros.
- R2: An accepted dispatch (`dispValid` and `dispReady`) takes the lowest-numbered free slot. `dispId` shows that slot before the edge and the next free slot after it. When all slots are held, `dispReady` is 0 and `dispId` is 0. A dispatch in that state is ignored, and slots and `issueAllowed` are unchanged.
- R3: An instruction with no hazard against any in-flight instruction has its `issueAllowed` bit set from the cycle after its dispatch. The bit stays set until its issue strobe.
- R4: If a new instruction reads a register (enable bit set, same 5-bit index) that an un-issued older instruction writes, it is blocked. It becomes allowed in the cycle after the producer's issue strobe (`issueValid` with `issueId`), even though the producer has not completed.
- R5: If a new instruction writes a register that an older instruction reads, it is blocked until every lane has reported read-done for that older slot. A report is `rdDoneValid[l]` with the slot number in `rdDoneId[l*IdW +: IdW]`. The block releases the new instruction in the cycle after the last report, even while the older instruction is still running.
- R6: Read-done reports from only some of the lanes leave the write-after-read block in place. Lanes may report in different cycles.
- R7: If a new instruction writes the same register as an older in-flight writer, it is blocked until that writer completes. Done-reports from only some of the lanes do not release it.
- R8: A slot is freed in the cycle after the last of its lanes reports done (`doneValid[l]` with `doneId[l*IdW +: IdW]`). It can then be dispatched again.
- R9: A read-done report that completes a slot's release in the same cycle as a dispatch means that the new instruction takes no write-after-read dependence on that slot.
- R10: An issue strobe or a completion in the same cycle as a dispatch means that the new instruction takes no read-after-write dependence on the issued slot, and no dependence of any kind on the completing slot.
- R11: A slot's `issueAllowed` bit is cleared in the cycle after its issue strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispSrcAEn | input | 1 | First source operand present |
| dispSrcA | input | 5 | First source register index |
| dispSrcBEn | input | 1 | Second source operand present |
| dispSrcB | input | 5 | Second source register index |
| dispDstEn | input | 1 | Destination present |
| dispDst | input | 5 | Destination register index |
| dispReady | output | 1 | A slot is free |
| dispId | output | IdW | Slot that the next dispatch will take |
| issueValid | input | 1 | Issue strobe |
| issueId | input | IdW | Slot being issued |
| rdDoneValid | input | NumLanes | Per-lane source-read-done strobe |
| rdDoneId | input | NumLanes*IdW | Per-lane slot for read-done |
| doneValid | input | NumLanes | Per-lane completion strobe |
| doneId | input | NumLanes*IdW | Per-lane slot for completion |
| issueAllowed | output | NumSlots | Per-slot permission to issue |

## Verification
The hardest cases to reach are those where a release event and a dispatch land on the same edge. The new instruction must see the post-event state of the older slot. Otherwise it picks up a stale write-after-read, read-after-write or write-after-write dependence that never clears.

The stimulus builds a table with several older slots in mixed states before each such case. It then drives the final lane's read-done, an issue strobe, or a full completion together with a dispatch whose registers collide with the affected slot. In each case the new slot must come out allowed.

The partial-report cases are reached by splitting one slot's lane reports across two cycles.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  localparam int unsigned RegIdxW = 5;

  typedef struct packed {
    logic                en;
    logic [RegIdxW-1:0]  idx;
  } vreg_t;

  typedef struct packed {
    vreg_t srcA;
    vreg_t srcB;
    vreg_t dst;
  } vinstr_t;

  function automatic logic regHit(vreg_t x, vreg_t y);
    return x.en && y.en && (x.idx == y.idx);
  endfunction
endpackage

// File: rtl/vsb_ctrl.sv
module vsb_ctrl #(
  parameter int unsigned NumSlots = 8,
  parameter int unsigned NumLanes = 4,
  parameter type strobe_t = logic,
  localparam int unsigned IdW = $clog2(NumSlots)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dispValid,
  input  logic                     issueValid,
  input  logic [IdW-1:0]           issueId,
  input  logic [NumLanes-1:0]      rdDoneValid,
  input  logic [NumLanes*IdW-1:0]  rdDoneId,
  input  logic [NumLanes-1:0]      doneValid,
  input  logic [NumLanes*IdW-1:0]  doneId,
  output logic                     dispReady,
  output logic [IdW-1:0]           dispId,
  output strobe_t                  st
);
  logic [NumSlots-1:0] valid, issued;
  logic [NumSlots-1:0] freeMask, allocCand, allocOh, freeOh, issueOh;
  logic [NumSlots-1:0] relNext, issuedNext;
  logic [NumLanes-1:0] rdSeen [NumSlots];
  logic [NumLanes-1:0] dnSeen [NumSlots];
  logic [NumLanes-1:0] rdHit  [NumSlots];
  logic [NumLanes-1:0] dnHit  [NumSlots];

  assign freeMask  = ~valid;
  assign allocCand = freeMask & (~freeMask + NumSlots'(1));
  assign dispReady = |freeMask;
  assign allocOh   = dispValid ? allocCand : '0;

  always_comb begin
    dispId = '0;
    for (int i = 0; i < NumSlots; i++) begin
      if (allocCand[i]) dispId = IdW'(i);
    end
  end

  for (genvar s = 0; s < NumSlots; s++) begin : g_slot
    for (genvar l = 0; l < NumLanes; l++) begin : g_lane
      assign rdHit[s][l] = rdDoneValid[l] && (rdDoneId[l*IdW +: IdW] == IdW'(s));
      assign dnHit[s][l] = doneValid[l] && (doneId[l*IdW +: IdW] == IdW'(s));
    end

    assign issueOh[s]    = issueValid && (issueId == IdW'(s));
    assign relNext[s]    = valid[s] && (&(rdSeen[s] | rdHit[s]));
    assign freeOh[s]     = valid[s] && (&(dnSeen[s] | dnHit[s]));
    assign issuedNext[s] = (issued[s] | issueOh[s]) & valid[s] & ~freeOh[s];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdSeen[s] <= '0;
        dnSeen[s] <= '0;
      end else if (valid[s] && !freeOh[s]) begin
        rdSeen[s] <= rdSeen[s] | rdHit[s];
        dnSeen[s] <= dnSeen[s] | dnHit[s];
      end else begin
        rdSeen[s] <= '0;
        dnSeen[s] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid  <= '0;
      issued <= '0;
    end else begin
      valid  <= (valid & ~freeOh) | allocOh;
      issued <= issuedNext;
    end
  end

  always_comb begin
    st            = '0;
    st.live       = valid;
    st.issuedNow  = issued;
    st.alloc      = allocOh;
    st.freeNow    = freeOh;
    st.issuedNext = issuedNext;
    st.relNext    = relNext;
  end
endmodule

// File: rtl/vsb_datapath.sv
module vsb_datapath import vsb_pkg::*; #(
  parameter int unsigned NumSlots = 8,
  parameter type strobe_t = logic
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vinstr_t              newInstr,
  input  strobe_t              st,
  output logic [NumSlots-1:0]  issueAllowed
);
  vinstr_t             slotInstr [NumSlots];
  logic [NumSlots-1:0] rawW [NumSlots];
  logic [NumSlots-1:0] warW [NumSlots];
  logic [NumSlots-1:0] wawW [NumSlots];
  logic [NumSlots-1:0] newRaw, newWar, newWaw, liveAfter;

  assign liveAfter = st.live & ~st.freeNow;

  for (genvar j = 0; j < NumSlots; j++) begin : g_cmp
    assign newRaw[j] = liveAfter[j] & ~st.issuedNext[j] &
                       (regHit(slotInstr[j].dst, newInstr.srcA) |
                        regHit(slotInstr[j].dst, newInstr.srcB));
    assign newWar[j] = liveAfter[j] & ~st.relNext[j] &
                       (regHit(slotInstr[j].srcA, newInstr.dst) |
                        regHit(slotInstr[j].srcB, newInstr.dst));
    assign newWaw[j] = liveAfter[j] & regHit(slotInstr[j].dst, newInstr.dst);
  end

  for (genvar s = 0; s < NumSlots; s++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotInstr[s] <= '0;
        rawW[s]      <= '0;
        warW[s]      <= '0;
        wawW[s]      <= '0;
      end else if (st.alloc[s]) begin
        slotInstr[s] <= newInstr;
        rawW[s]      <= newRaw;
        warW[s]      <= newWar;
        wawW[s]      <= newWaw;
      end else if (st.freeNow[s]) begin
        rawW[s] <= '0;
        warW[s] <= '0;
        wawW[s] <= '0;
      end else begin
        rawW[s] <= rawW[s] & ~st.issuedNext & ~st.freeNow;
        warW[s] <= warW[s] & ~st.relNext & ~st.freeNow;
        wawW[s] <= wawW[s] & ~st.freeNow;
      end
    end

    assign issueAllowed[s] = st.live[s] & ~st.issuedNow[s] &
                             ~(|(rawW[s] | warW[s] | wawW[s]));
  end
endmodule

// File: rtl/vec_dep_scoreboard.sv
module vec_dep_scoreboard import vsb_pkg::*; #(
  parameter int unsigned NumSlots = 8,
  parameter int unsigned NumLanes = 4,
  localparam int unsigned IdW = $clog2(NumSlots)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dispValid,
  input  logic                     dispSrcAEn,
  input  logic [RegIdxW-1:0]       dispSrcA,
  input  logic                     dispSrcBEn,
  input  logic [RegIdxW-1:0]       dispSrcB,
  input  logic                     dispDstEn,
  input  logic [RegIdxW-1:0]       dispDst,
  output logic                     dispReady,
  output logic [IdW-1:0]           dispId,
  input  logic                     issueValid,
  input  logic [IdW-1:0]           issueId,
  input  logic [NumLanes-1:0]      rdDoneValid,
  input  logic [NumLanes*IdW-1:0]  rdDoneId,
  input  logic [NumLanes-1:0]      doneValid,
  input  logic [NumLanes*IdW-1:0]  doneId,
  output logic [NumSlots-1:0]      issueAllowed
);
  typedef struct packed {
    logic [NumSlots-1:0] live;
    logic [NumSlots-1:0] issuedNow;
    logic [NumSlots-1:0] alloc;
    logic [NumSlots-1:0] freeNow;
    logic [NumSlots-1:0] issuedNext;
    logic [NumSlots-1:0] relNext;
  } strobe_t;

  strobe_t strobes;
  vinstr_t newInstr;

  assign newInstr.srcA = '{en: dispSrcAEn, idx: dispSrcA};
  assign newInstr.srcB = '{en: dispSrcBEn, idx: dispSrcB};
  assign newInstr.dst  = '{en: dispDstEn,  idx: dispDst};

  vsb_ctrl #(.NumSlots(NumSlots), .NumLanes(NumLanes), .strobe_t(strobe_t)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .dispValid   (dispValid),
    .issueValid  (issueValid),
    .issueId     (issueId),
    .rdDoneValid (rdDoneValid),
    .rdDoneId    (rdDoneId),
    .doneValid   (doneValid),
    .doneId      (doneId),
    .dispReady   (dispReady),
    .dispId      (dispId),
    .st          (strobes)
  );

  vsb_datapath #(.NumSlots(NumSlots), .strobe_t(strobe_t)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .newInstr     (newInstr),
    .st           (strobes),
    .issueAllowed (issueAllowed)
  );
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
  parameter int unsigned NumSlots = 8,
  parameter int unsigned NumLanes = 4,
  localparam int unsigned IdW = $clog2(NumSlots)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     dispValid,
  input logic                     dispReady,
  input logic [IdW-1:0]           dispId,
  input logic                     issueValid,
  input logic [IdW-1:0]           issueId,
  input logic [NumLanes-1:0]      doneValid,
  input logic [NumLanes*IdW-1:0]  doneId,
  input logic [NumSlots-1:0]      issueAllowed,
  input logic [NumSlots-1:0]      live
);
  // R2: an accepted dispatch occupies the slot that was offered
  p_alloc_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispReady |=> live[$past(dispId)]);

  // R4: only slots with no remaining hazard are issued
  p_issue_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> issueAllowed[issueId]);

  // R11: an issued slot loses its permission on the next cycle
  p_issued_drops_r11: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !issueAllowed[$past(issueId)]);

  for (genvar s = 0; s < NumSlots; s++) begin : g_slot
    // R3: permission, once granted, stays until the slot is issued
    p_allowed_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
      issueAllowed[s] && !(issueValid && issueId == IdW'(s)) |=> issueAllowed[s]);

    // R8: a free slot never reports permission
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
      !live[s] |-> !issueAllowed[s]);
  end

  for (genvar l = 0; l < NumLanes; l++) begin : g_lane
    // R8: completion is only reported for a held slot
    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
      doneValid[l] |-> live[doneId[l*IdW +: IdW]]);
  end
endmodule

bind vec_dep_scoreboard vsb_checker #(.NumSlots(NumSlots), .NumLanes(NumLanes)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .dispValid    (dispValid),
  .dispReady    (dispReady),
  .dispId       (dispId),
  .issueValid   (issueValid),
  .issueId      (issueId),
  .doneValid    (doneValid),
  .doneId       (doneId),
  .issueAllowed (issueAllowed),
  .live         (strobes.live)
);

// File: tb/sim_vec_dep_scoreboard.sv
module sim_vec_dep_scoreboard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0;
  logic dispSrcAEn = 1'b0, dispSrcBEn = 1'b0, dispDstEn = 1'b0;
  logic [4:0] dispSrcA = '0, dispSrcB = '0, dispDst = '0;
  logic dispReady;
  logic [2:0] dispId;
  logic issueValid = 1'b0;
  logic [2:0] issueId = '0;
  logic [3:0] rdDoneValid = '0, doneValid = '0;
  logic [11:0] rdDoneId = '0, doneId = '0;
  logic [7:0] issueAllowed;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vec_dep_scoreboard u0 (
    .clk(clk), .rstN(rstN), .dispValid(dispValid),
    .dispSrcAEn(dispSrcAEn), .dispSrcA(dispSrcA),
    .dispSrcBEn(dispSrcBEn), .dispSrcB(dispSrcB),
    .dispDstEn(dispDstEn), .dispDst(dispDst),
    .dispReady(dispReady), .dispId(dispId),
    .issueValid(issueValid), .issueId(issueId),
    .rdDoneValid(rdDoneValid), .rdDoneId(rdDoneId),
    .doneValid(doneValid), .doneId(doneId),
    .issueAllowed(issueAllowed)
  );

  // register operand: bit5 = present, bits4:0 = index
  localparam logic [5:0] NO = 6'h00;
  localparam logic [5:0] V1 = 6'h21, V2 = 6'h22, V3 = 6'h23, V4 = 6'h24, V5 = 6'h25;
  localparam logic [1:0] EN = 2'd0, EI = 2'd1, ER = 2'd2, ED = 2'd3;

  typedef struct packed {
    logic       disp;
    logic [1:0] ev;
    logic [2:0] id;
    logic [3:0] lanes;
    logic [5:0] a;
    logic [5:0] b;
    logic [5:0] d;
    logic [3:0] tag;
    logic [7:0] expAllowed;
    logic       expReady;
    logic [2:0] expId;
  } step_t;

  localparam int NSteps = 21;
  localparam step_t Steps [NSteps] = '{
    '{1'b1, EN, 3'd0, 4'h0, V1, V2, V3, 4'd3,  8'h01, 1'b1, 3'd1}, // R3 independent
    '{1'b1, EN, 3'd0, 4'h0, V3, NO, V4, 4'd4,  8'h01, 1'b1, 3'd2}, // R4 raw on slot0
    '{1'b0, EI, 3'd0, 4'h0, NO, NO, NO, 4'd4,  8'h02, 1'b1, 3'd2}, // R4 chain after issue
    '{1'b1, EN, 3'd0, 4'h0, NO, NO, V1, 4'd5,  8'h02, 1'b1, 3'd3}, // R5 war on slot0
    '{1'b0, ER, 3'd0, 4'h7, NO, NO, NO, 4'd6,  8'h02, 1'b1, 3'd3}, // R6 partial reads
    '{1'b0, ER, 3'd0, 4'h8, NO, NO, NO, 4'd5,  8'h06, 1'b1, 3'd3}, // R5 last lane
    '{1'b0, EI, 3'd1, 4'h0, NO, NO, NO, 4'd11, 8'h04, 1'b1, 3'd3}, // R11
    '{1'b0, EI, 3'd2, 4'h0, NO, NO, NO, 4'd11, 8'h00, 1'b1, 3'd3}, // R11
    '{1'b1, EN, 3'd0, 4'h0, V5, NO, V4, 4'd7,  8'h00, 1'b1, 3'd4}, // R7 waw on slot1
    '{1'b0, ED, 3'd1, 4'h3, NO, NO, NO, 4'd7,  8'h00, 1'b1, 3'd4}, // R7 partial done
    '{1'b0, ED, 3'd1, 4'hC, NO, NO, NO, 4'd8,  8'h08, 1'b1, 3'd1}, // R8 slot1 freed
    '{1'b1, ER, 3'd3, 4'hF, NO, NO, V5, 4'd9,  8'h0A, 1'b1, 3'd4}, // R9 release same cycle
    '{1'b1, ED, 3'd0, 4'hF, NO, NO, V3, 4'd10, 8'h1A, 1'b1, 3'd0}, // R10 completion same cycle
    '{1'b1, EI, 3'd1, 4'h0, V5, NO, NO, 4'd10, 8'h19, 1'b1, 3'd5}, // R10 issue same cycle
    '{1'b1, EN, 3'd0, 4'h0, V4, NO, NO, 4'd4,  8'h19, 1'b1, 3'd6}, // R4 raw on slot3
    '{1'b1, EN, 3'd0, 4'h0, NO, NO, NO, 4'd3,  8'h59, 1'b1, 3'd7}, // R3
    '{1'b1, EN, 3'd0, 4'h0, NO, NO, NO, 4'd2,  8'hD9, 1'b0, 3'd0}, // R2 table full
    '{1'b1, EN, 3'd0, 4'h0, NO, NO, NO, 4'd2,  8'hD9, 1'b0, 3'd0}, // R2 dispatch ignored
    '{1'b0, EI, 3'd6, 4'h0, NO, NO, NO, 4'd11, 8'h99, 1'b0, 3'd0}, // R11
    '{1'b0, ED, 3'd6, 4'hF, NO, NO, NO, 4'd8,  8'h99, 1'b1, 3'd6}, // R8 reuse offered
    '{1'b0, EI, 3'd3, 4'h0, NO, NO, NO, 4'd4,  8'hB1, 1'b1, 3'd6}  // R4 slot5 released
  };

  task automatic check(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic idleInputs();
    dispValid = 1'b0; dispSrcAEn = 1'b0; dispSrcBEn = 1'b0; dispDstEn = 1'b0;
    issueValid = 1'b0; rdDoneValid = '0; doneValid = '0;
  endtask

  task automatic applyStep(input step_t v);
    dispValid  = v.disp;
    dispSrcAEn = v.a[5]; dispSrcA = v.a[4:0];
    dispSrcBEn = v.b[5]; dispSrcB = v.b[4:0];
    dispDstEn  = v.d[5]; dispDst  = v.d[4:0];
    issueValid = (v.ev == EI);
    issueId    = v.id;
    rdDoneValid = (v.ev == ER) ? v.lanes : 4'h0;
    rdDoneId    = {4{v.id}};
    doneValid   = (v.ev == ED) ? v.lanes : 4'h0;
    doneId      = {4{v.id}};
    @(posedge clk);
    @(negedge clk);
    idleInputs();
    check(int'(v.tag), "issueAllowed", 32'(issueAllowed), 32'(v.expAllowed));
    check(int'(v.tag), "dispReady", 32'(dispReady), 32'(v.expReady));
    check(int'(v.tag), "dispId", 32'(dispId), 32'(v.expId));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    $display("FAIL watchdog expired: got hang expected completion");
    checks++;
    fails++;
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held in reset
    check(1, "reset issueAllowed", 32'(issueAllowed), 32'h0);
    check(1, "reset dispReady", 32'(dispReady), 32'h1);
    check(1, "reset dispId", 32'(dispId), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(1, "post-reset issueAllowed", 32'(issueAllowed), 32'h0);

    for (int i = 0; i < NSteps; i++) applyStep(Steps[i]);

    // R1: reset with busy slots returns to the empty state
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, "re-reset issueAllowed", 32'(issueAllowed), 32'h0);
    check(1, "re-reset dispReady", 32'(dispReady), 32'h1);
    check(1, "re-reset dispId", 32'(dispId), 32'h0);

    // R7: completion on the same edge as a colliding dispatch (R10) leaves no waw
    applyStep('{1'b1, EN, 3'd0, 4'h0, NO, NO, V2, 4'd7,  8'h01, 1'b1, 3'd1});
    applyStep('{1'b0, EI, 3'd0, 4'h0, NO, NO, NO, 4'd11, 8'h00, 1'b1, 3'd1});
    applyStep('{1'b1, ED, 3'd0, 4'hF, NO, NO, V2, 4'd10, 8'h02, 1'b1, 3'd0});
    finishRun();
  end
endmodule